// File: doc/BRIEF.md
# Ring Descriptor DMA Engine

This block is a single-channel DMA engine that walks a closed ring of descriptors held in memory and moves 16-bit audio halfwords between the buffers they name and a small sample FIFO. Each descriptor is three halfwords. The first is the buffer address. The second holds the byte count, with a flag that asks for an interrupt when that descriptor finishes. The third is the address of the next descriptor. The last descriptor points back to the first, so the engine runs until software stops it. A typical ring is sixteen 1024-byte blocks covering a 16 KiB buffer.

Software loads the first descriptor address into the pointer register and then writes the control word with the run bit set. To stop the engine, it writes a control word that holds only the load bit. The run bit is then clear and the engine drops back to idle. The current buffer pointer is always visible on a port, so software can track the playback or capture position. A sticky interrupt flag is set at the end of every descriptor that asked for one. Reading the control word clears it.

The walker is a state machine with five states:
- IDLE waits for the run bit. IDLE→GET_BUF happens when run is set.
- GET_BUF reads the buffer address. GET_BUF→GET_CNT is unconditional.
- GET_CNT reads the count and the interrupt flag. GET_CNT→GET_NEXT is unconditional.
- GET_NEXT reads the next pointer. GET_NEXT→MOVE happens when the count is non-zero. GET_NEXT→GET_BUF happens when the count is zero, and that descriptor completes at once.
- MOVE transfers one halfword per beat. MOVE→GET_BUF happens after the final beat.

From any state, a clear run bit forces the walker to IDLE on the next cycle.

Top module: `dma_ring_engine`

## Requirements
- R1: After reset, the control read value is 0, `irq` is 0, and none of `fifo_push`, `fifo_pop` or `mem_we` is asserted.
- R2: A control write with bit 4 (run) set while idle fetches the descriptor at the loaded pointer. The engine presents the address pointer+0 (buffer), then pointer+2 (count word: bit 15 is interrupt-enable, bits 13:0 are the byte count), then pointer+4 (next pointer), on consecutive cycles starting one cycle after the write.
- R3: In transmit mode (control bit 2 clear), the halfwords of each buffer are pushed into the FIFO in ascending address order. `bptr` advances by 2 on every beat.
- R4: In receive mode (control bit 2 set), halfwords popped from the FIFO are written to consecutive buffer addresses, starting at the buffer address.
- R5: No push occurs while `fifo_full` is high, and no pop occurs while `fifo_empty` is high. Stalls lose and repeat no data.
- R6: When a descriptor's bytes are done, the engine follows that descriptor's next pointer. A ring whose last entry points back to the first repeats the same sequence endlessly.
- R7: The sticky interrupt flag (`irq`, control read bit 0) is set when a descriptor whose bit 15 is set completes. It is never set by descriptors whose bit 15 is clear.
- R8: Reading the control word returns bit 0 equal to `irq`, and clears `irq` from the next cycle onward, unless a completion lands in that same cycle.
- R9: A control write with bit 4 clear (for example, the load bit 1 alone) stops the engine. No further push, pop or memory write occurs, and control read bit 4 is 0.
- R10: Control bits 31:24 (FIFO end), 23:16 (FIFO begin), 15:8 (high-water mark), 4, 2 and 1 read back as written. Bit 0 always reads the interrupt flag, not the written value.
- R11: `bptr` shows the address of the next halfword to be moved, including while the engine is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects descriptor pointer |
| reg_wdata | input | 32 | Register write data |
| ctrl_rd | input | 1 | Control read strobe (clears interrupt) |
| ctrl_rdata | output | 32 | Control read value |
| irq | output | 1 | Sticky interrupt flag |
| bptr | output | 16 | Current buffer pointer |
| mem_addr | output | 16 | Memory byte address (halfword aligned) |
| mem_rdata | input | 16 | Memory read data, same cycle |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| fifo_push | output | 1 | Push a halfword into the FIFO (transmit) |
| fifo_wdata | output | 16 | Halfword pushed |
| fifo_full | input | 1 | FIFO cannot accept |
| fifo_pop | output | 1 | Pop a halfword from the FIFO (receive) |
| fifo_rdata | input | 16 | Head halfword of the FIFO |
| fifo_empty | input | 1 | FIFO has no data |

## Verification
Transmit is tried on a three-entry ring whose buffers have different lengths and different interrupt flags. It runs for two full laps while the FIFO stalls the engine periodically. This separates wrong ordering, wrong wrap and data lost or repeated during stalls. A single self-pointing descriptor, run once with the interrupt flag clear and once with it set, tells whether the flag follows the per-descriptor flag and whether a read clears it. Receive is tried with a FIFO that runs dry mid-ring, which shows the write addresses, the stall on empty and the visible buffer pointer at the stall.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_BUF,
        ST_GET_CNT,
        ST_GET_NEXT,
        ST_MOVE
    } walk_state_t;

    localparam int CTL_IRQ  = 0;
    localparam int CTL_LOAD = 1;
    localparam int CTL_RCV  = 2;
    localparam int CTL_RUN  = 4;
endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
    import dma_ring_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [CTL_W-1:0] wdata,
    input  logic             rd_ctl,
    input  logic             irq_set,
    output logic [CTL_W-1:0] rdata,
    output logic             run,
    output logic             rcv,
    output logic             irq
);
    logic [CTL_W-1:0] ctl_q;
    logic             irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (wr_ctl) ctl_q <= wdata;
            if (irq_set)     irq_q <= 1'b1;
            else if (rd_ctl) irq_q <= 1'b0;
        end
    end

    always_comb begin
        rdata          = ctl_q;
        rdata[CTL_IRQ] = irq_q;
    end

    assign run = ctl_q[CTL_RUN];
    assign rcv = ctl_q[CTL_RCV];
    assign irq = irq_q;

    // R7: a completion always leaves the flag set
    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq_q);
    // R8: a read with no new completion clears the flag
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl && !irq_set) |=> !irq_q);
endmodule

// File: rtl/dma_ring_walker.sv
module dma_ring_walker
    import dma_ring_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 14,
    parameter int IE_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rcv,
    input  logic              dptr_ld,
    input  logic [ADDR_W-1:0] dptr_val,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    input  logic              fifo_full,
    output logic              fifo_pop,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              fifo_empty,
    output logic [ADDR_W-1:0] bptr,
    output logic              irq_set
);
    localparam int STEP     = DATA_W / 8;
    localparam int OFS_CNT  = STEP;
    localparam int OFS_NEXT = 2 * STEP;

    walk_state_t       st_q, st_d;
    logic [ADDR_W-1:0] dptr_q, bptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ie_q;
    logic              beat, last;

    assign beat = (st_q == ST_MOVE) && run && (rcv ? !fifo_empty : !fifo_full);
    assign last = (cnt_q <= CNT_W'(STEP));

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dptr_q <= '0;
            bptr_q <= '0;
            cnt_q  <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (st_q == ST_GET_NEXT) dptr_q <= mem_rdata[ADDR_W-1:0];
            else if (dptr_ld)        dptr_q <= dptr_val;
            if (st_q == ST_GET_BUF) bptr_q <= mem_rdata[ADDR_W-1:0];
            if (st_q == ST_GET_CNT) begin
                cnt_q <= mem_rdata[CNT_W-1:0];
                ie_q  <= mem_rdata[IE_BIT];
            end
            if (beat) begin
                bptr_q <= bptr_q + ADDR_W'(STEP);
                cnt_q  <= cnt_q - CNT_W'(STEP);
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        irq_set  = 1'b0;
        mem_addr = bptr_q;
        unique case (st_q)
            ST_IDLE:     if (run) st_d = ST_GET_BUF;
            ST_GET_BUF:  begin mem_addr = dptr_q; st_d = ST_GET_CNT; end
            ST_GET_CNT:  begin mem_addr = dptr_q + ADDR_W'(OFS_CNT); st_d = ST_GET_NEXT; end
            ST_GET_NEXT: begin
                mem_addr = dptr_q + ADDR_W'(OFS_NEXT);
                if (cnt_q == '0) begin
                    st_d    = ST_GET_BUF;
                    irq_set = ie_q && run;
                end else begin
                    st_d = ST_MOVE;
                end
            end
            ST_MOVE: if (beat && last) begin
                st_d    = ST_GET_BUF;
                irq_set = ie_q;
            end
            default: st_d = ST_IDLE;
        endcase
        if (!run) st_d = ST_IDLE;
    end

    assign fifo_push  = beat && !rcv;
    assign fifo_pop   = beat && rcv;
    assign mem_we     = beat && rcv;
    assign fifo_wdata = mem_rdata;
    assign mem_wdata  = fifo_rdata;
    assign bptr       = bptr_q;

    // R5: never push into a full FIFO
    p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);
    // R5: never pop from an empty FIFO
    p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);
    // R3: each beat moves the buffer pointer by one halfword
    p_bptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push || mem_we) |=> bptr_q == $past(bptr_q) + ADDR_W'(STEP));
    // R2: a run request from idle starts a descriptor fetch
    p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && run) |=> st_q == ST_GET_BUF);
    // R9: a cleared run bit returns the walker to idle
    p_halt_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q == ST_IDLE);
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
    import dma_ring_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 14,
    parameter int IE_BIT = 15,
    parameter int CTL_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [CTL_W-1:0]  reg_wdata,
    input  logic              ctrl_rd,
    output logic [CTL_W-1:0]  ctrl_rdata,
    output logic              irq,
    output logic [ADDR_W-1:0] bptr,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    input  logic              fifo_full,
    output logic              fifo_pop,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              fifo_empty
);
    logic run, rcv, irq_set;

    dma_ring_regs #(.CTL_W(CTL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (reg_wr && !reg_sel),
        .wdata   (reg_wdata),
        .rd_ctl  (ctrl_rd),
        .irq_set (irq_set),
        .rdata   (ctrl_rdata),
        .run     (run),
        .rcv     (rcv),
        .irq     (irq)
    );

    dma_ring_walker #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .IE_BIT (IE_BIT)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .rcv        (rcv),
        .dptr_ld    (reg_wr && reg_sel),
        .dptr_val   (reg_wdata[ADDR_W-1:0]),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .fifo_full  (fifo_full),
        .fifo_pop   (fifo_pop),
        .fifo_rdata (fifo_rdata),
        .fifo_empty (fifo_empty),
        .bptr       (bptr),
        .irq_set    (irq_set)
    );
endmodule

// File: tb/dma_ring_engine_tb.sv
module dma_ring_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0, ctrl_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        irq;
    logic [15:0] bptr, mem_addr, mem_rdata, mem_wdata, fifo_wdata, fifo_rdata;
    logic        mem_we, fifo_push, fifo_pop, fifo_full, fifo_empty;

    logic [15:0] mem [0:1023];
    logic [15:0] sb_q [$];
    logic [15:0] rx_vals [0:5];
    int          rx_idx = 0;
    logic        rx_en = 1'b0;
    logic        hold_full = 1'b0, stall_en = 1'b0, sb_en = 1'b0;
    logic [1:0]  cyc = '0;
    int          push_cnt = 0, stall_bad = 0;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    dma_ring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .ctrl_rdata(ctrl_rdata),
        .irq(irq), .bptr(bptr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty)
    );

    assign mem_rdata  = mem[mem_addr[10:1]];
    assign fifo_full  = hold_full || (stall_en && cyc == 2'b11);
    assign fifo_empty = !(rx_en && rx_idx < 6);
    assign fifo_rdata = rx_vals[rx_idx < 6 ? rx_idx : 0];

    always @(posedge clk) begin
        cyc <= cyc + 2'd1;
        if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
        if (fifo_pop) rx_idx <= rx_idx + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor, sampled in the low phase
    always @(negedge clk) begin
        if (rst_n && fifo_push) begin
            push_cnt++;
            if (fifo_full) stall_bad++;
            if (sb_en) begin
                if (sb_q.size() == 0) check("R6 unexpected push", {16'h0, fifo_wdata}, 32'hFFFF_FFFF);
                else check("R3 push data", {16'h0, fifo_wdata}, {16'h0, sb_q.pop_front()});
            end
        end
    end

    task automatic put(input logic [15:0] a, input logic [15:0] v);
        mem[a[10:1]] = v;
    endtask

    task automatic desc(input logic [15:0] a, input logic [15:0] buf_a, input logic [15:0] cnt, input logic [15:0] nxt);
        put(a, buf_a); put(a + 16'd2, cnt); put(a + 16'd4, nxt);
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] v);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic ctrl_read(output logic [31:0] v);
        @(posedge clk); #1;
        ctrl_rd = 1'b1;
        #1 v = ctrl_rdata;
        @(posedge clk); #1;
        ctrl_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sb_lap();
        for (int i = 0; i < 4; i++) sb_q.push_back(16'hA000 + 16'(i));
        for (int i = 0; i < 2; i++) sb_q.push_back(16'hB000 + 16'(i));
        for (int i = 0; i < 3; i++) sb_q.push_back(16'hC000 + 16'(i));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int snap;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 6; i++) rx_vals[i] = 16'h5000 + 16'(i * 3);
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 strobes", {29'h0, fifo_push, fifo_pop, mem_we}, 32'h0);
        ctrl_read(rv);
        check("R1 ctrl read", rv, 32'h0);

        // R10 field readback, bit 0 shows the flag
        reg_write(1'b0, 32'h0A04_0207);
        ctrl_read(rv);
        check("R10 ctrl fields", rv, 32'h0A04_0206);

        // R3 R5 R6 transmit over a three-entry ring, two laps, periodic stalls
        desc(16'h0100, 16'h0200, 16'h8008, 16'h0108);
        desc(16'h0108, 16'h0240, 16'h0004, 16'h0110);
        desc(16'h0110, 16'h0280, 16'h8006, 16'h0100);
        for (int i = 0; i < 4; i++) put(16'h0200 + 16'(2 * i), 16'hA000 + 16'(i));
        for (int i = 0; i < 2; i++) put(16'h0240 + 16'(2 * i), 16'hB000 + 16'(i));
        for (int i = 0; i < 3; i++) put(16'h0280 + 16'(2 * i), 16'hC000 + 16'(i));
        sb_lap(); sb_lap();
        sb_en = 1'b1; stall_en = 1'b1; push_cnt = 0;
        reg_write(1'b1, 32'h0000_0100);
        reg_write(1'b0, 32'h0201_0212);
        while (push_cnt < 18) @(negedge clk);
        @(posedge clk); #1;
        hold_full = 1'b1;
        check("R6 ring laps consumed", sb_q.size(), 0);
        check("R5 no push while full", stall_bad, 0);
        // R9 stop with load bit only
        reg_write(1'b0, 32'h0000_0002);
        hold_full = 1'b0; stall_en = 1'b0; sb_en = 1'b0;
        snap = push_cnt;
        idle(20);
        check("R9 no push after stop", push_cnt, snap);
        ctrl_read(rv);
        check("R9 run bit clear", {31'h0, rv[4]}, 32'h0);

        // R7 self-pointing descriptor without interrupt flag
        idle(2);
        check("R8 flag cleared by read", {31'h0, irq}, 32'h0);
        desc(16'h0180, 16'h0200, 16'h0004, 16'h0180);
        snap = push_cnt;
        reg_write(1'b1, 32'h0000_0180);
        reg_write(1'b0, 32'h0000_0012);
        idle(40);
        reg_write(1'b0, 32'h0000_0002);
        check("R7 no flag without enable", {31'h0, irq}, 32'h0);
        check("R6 self loop progressed", {31'h0, push_cnt > snap + 8}, 32'h1);

        // R7 R8 same descriptor with interrupt flag
        put(16'h0182, 16'h8004);
        reg_write(1'b0, 32'h0000_0012);
        idle(40);
        reg_write(1'b0, 32'h0000_0002);
        idle(2);
        check("R7 flag set on completion", {31'h0, irq}, 32'h1);
        ctrl_read(rv);
        check("R8 read shows flag", {31'h0, rv[0]}, 32'h1);
        check("R8 flag cleared after read", {31'h0, irq}, 32'h0);

        // R2 R4 R5 R11 receive ring, FIFO runs dry
        desc(16'h0140, 16'h0300, 16'h8008, 16'h0148);
        desc(16'h0148, 16'h0320, 16'h0004, 16'h0140);
        reg_write(1'b1, 32'h0000_0140);
        reg_write(1'b0, 32'h0000_0016);
        @(posedge clk); #1;
        check("R2 fetch buffer addr", {16'h0, mem_addr}, 32'h0140);
        @(posedge clk); #1;
        check("R2 fetch count addr", {16'h0, mem_addr}, 32'h0142);
        @(posedge clk); #1;
        check("R2 fetch next addr", {16'h0, mem_addr}, 32'h0144);
        rx_en = 1'b1;
        while (rx_idx < 6) @(negedge clk);
        idle(10);
        check("R11 bptr at stall", {16'h0, bptr}, 32'h0300);
        check("R5 no pop while empty", {31'h0, fifo_pop}, 32'h0);
        check("R7 receive completion flag", {31'h0, irq}, 32'h1);
        reg_write(1'b0, 32'h0000_0002);
        for (int i = 0; i < 4; i++)
            check("R4 receive data buf0", {16'h0, mem[(16'h0300 + 16'(2 * i)) >> 1]}, {16'h0, rx_vals[i]});
        for (int i = 0; i < 2; i++)
            check("R4 receive data buf1", {16'h0, mem[(16'h0320 + 16'(2 * i)) >> 1]}, {16'h0, rx_vals[4 + i]});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule